// File: doc/BRIEF.md
# Multi-register load sequencer

This block carries out the load instructions that write more than one general-purpose register from a single issue. It supports two operations. The first is a word-multiple load. It begins at a target register and writes every register up to the last one. Each register takes one 32-bit word, zero-extended to the register width, and the address rises by four bytes per register. The second is a quadword load into an even/odd register pair. Which register takes which doubleword depends on the byte order in force, and little-endian mode also byte-reverses both doublewords.

The start address is computed outside and presented with the start pulse. The sequencer then issues one read at a time on a request/response memory port, and turns each response into one register write command carrying a register number and 64-bit data. `busy_o` stays high for the whole operation. `done_o` pulses once after the final write. A quadword request that names an odd register is refused with a one-cycle `invalid_o` pulse and makes no memory access.

Top module: `mreg_load_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `invalid_o`, `rd_req_o` and `wr_en_o` are all low.
- R2: A word-multiple load (`quad_i`=0) with target t writes registers t, t+1, ... 31 in ascending order, one write per register. t=31 gives one write and t=0 gives 32 writes.
- R3: Word-multiple step k reads with `rd_dword_o`=0 at address `ea_i`+4k. The register receives `rd_data_i[31:0]` in bits 31:0, and bits 63:32 are zero whatever the upper response bits hold.
- R4: A quadword load (`quad_i`=1) with `le_i`=0 reads `ea_i` and then `ea_i`+8, both with `rd_dword_o`=1. Register t receives the first doubleword unchanged and register t+1 receives the second.
- R5: A quadword load with `le_i`=1 makes the same two reads. Register t+1 receives the byte-reversed doubleword from `ea_i` and register t receives the byte-reversed doubleword from `ea_i`+8. Byte i of the result is byte 7-i of the response.
- R6: A quadword start with an odd target pulses `invalid_o` for exactly one cycle, in the cycle after the start. No read is issued, no register is written and `busy_o` stays low.
- R7: At most one read is outstanding. `rd_req_o` is high for a single cycle per read, and the next read is issued only after the response to the previous one.
- R8: `done_o` is high for exactly one cycle, the cycle after the last register write. `busy_o` is low in the cycle after that.
- R9: `busy_o` rises in the cycle after an accepted start and stays high through the `done_o` cycle. A start presented while busy, including in the `done_o` cycle, is ignored and does not change the reads or writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| quad_i | input | 1 | 1 = quadword pair load, 0 = word-multiple load |
| le_i | input | 1 | 1 = little-endian pair assignment with byte reversal |
| rt_i | input | 5 | First target register |
| ea_i | input | 64 | Start address |
| rd_req_o | output | 1 | Read request, one cycle per read |
| rd_addr_o | output | 64 | Read address |
| rd_dword_o | output | 1 | 1 = 8-byte read, 0 = 4-byte read |
| rd_rsp_i | input | 1 | Read response valid |
| rd_data_i | input | 64 | Read data; word reads use bits 31:0 |
| wr_en_o | output | 1 | Register write command valid |
| wr_reg_o | output | 5 | Register number to write |
| wr_data_o | output | 64 | Register write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| invalid_o | output | 1 | One-cycle pulse for a refused odd-pair quadword start |

## Verification
The checks assume that the memory side answers each read exactly once. They also assume that no response is raised before the cycle following the request or while no read is pending. The outstanding-read and write-ordering properties depend on those limits. The bench responder records each observed request and answers it after a programmed latency of zero or more further cycles, starting no earlier than the next cycle, and it never raises a response on its own. Start pulses are driven during busy phases and in the completion cycle to exercise the ignore rule, but always with legal field values.

// File: rtl/mreg_load_pkg.sv
package mreg_load_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/mreg_seq_ctrl.sv
module mreg_seq_ctrl
  import mreg_load_pkg::*;
#(
  parameter int SW = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             rsp_i,
  input  logic             last_i,
  output seq_state_e       state_o,
  output logic [SW-1:0]    step_o
);
  seq_state_e    state_q;
  logic [SW-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_i) begin
            state_q <= ST_ISSUE;
            step_q  <= '0;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT:  if (rsp_i) state_q <= ST_WRITE;
        ST_WRITE: begin
          if (last_i) state_q <= ST_DONE;
          else begin
            state_q <= ST_ISSUE;
            step_q  <= step_q + 1'b1;
          end
        end
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign step_o  = step_q;
endmodule

// File: rtl/mreg_addr_gen.sv
module mreg_addr_gen #(
  parameter int AW     = 64,
  parameter int XLEN   = 64,
  parameter int WORD_W = 32,
  parameter int RW     = 5,
  parameter int SW     = 6
) (
  input  logic [AW-1:0] base_i,
  input  logic [RW-1:0] rt_i,
  input  logic [SW-1:0] step_i,
  input  logic          quad_i,
  input  logic          le_i,
  output logic [AW-1:0] addr_o,
  output logic [RW-1:0] reg_o,
  output logic          last_o
);
  localparam int WSH = $clog2(WORD_W / 8);
  localparam int DSH = $clog2(XLEN / 8);

  logic [AW-1:0] off_word, off_dword;
  logic [RW-1:0] reg_multi, reg_pair;

  assign off_word  = AW'(step_i) << WSH;
  assign off_dword = AW'(step_i) << DSH;
  assign reg_multi = rt_i + step_i[RW-1:0];
  // little-endian pair: first read lands in the odd register
  assign reg_pair  = {rt_i[RW-1:1], step_i[0] ^ le_i};

  always_comb begin
    if (quad_i) begin
      addr_o = base_i + off_dword;
      reg_o  = reg_pair;
      last_o = step_i[0];
    end else begin
      addr_o = base_i + off_word;
      reg_o  = reg_multi;
      last_o = &reg_multi;
    end
  end
endmodule

// File: rtl/mreg_data_fmt.sv
module mreg_data_fmt #(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  logic [XLEN-1:0] raw_i,
  input  logic            quad_i,
  input  logic            le_i,
  output logic [XLEN-1:0] fmt_o
);
  localparam int NB = XLEN / 8;

  logic [XLEN-1:0] swapped;

  for (genvar b = 0; b < NB; b++) begin : g_swap
    assign swapped[b*8 +: 8] = raw_i[XLEN-1-b*8 -: 8];
  end

  always_comb begin
    if (!quad_i)   fmt_o = {{(XLEN-WORD_W){1'b0}}, raw_i[WORD_W-1:0]};
    else if (le_i) fmt_o = swapped;
    else           fmt_o = raw_i;
  end
endmodule

// File: rtl/mreg_load_seq.sv
module mreg_load_seq
  import mreg_load_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int AW     = 64,
  parameter int NREG   = 32,
  parameter int WORD_W = 32,
  parameter int RW     = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            quad_i,
  input  logic            le_i,
  input  logic [RW-1:0]   rt_i,
  input  logic [AW-1:0]   ea_i,
  output logic            rd_req_o,
  output logic [AW-1:0]   rd_addr_o,
  output logic            rd_dword_o,
  input  logic            rd_rsp_i,
  input  logic [XLEN-1:0] rd_data_i,
  output logic            wr_en_o,
  output logic [RW-1:0]   wr_reg_o,
  output logic [XLEN-1:0] wr_data_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            invalid_o
);
  localparam int SW = RW + 1;

  seq_state_e      state;
  logic [SW-1:0]   step;
  logic [AW-1:0]   base_q;
  logic [RW-1:0]   rt_q;
  logic            quad_q, le_q;
  logic            idle, bad_pair, accept, last;
  logic [AW-1:0]   cur_addr;
  logic [RW-1:0]   cur_reg;
  logic [XLEN-1:0] fmt_data;
  logic [RW-1:0]   wr_reg_q;
  logic [XLEN-1:0] wr_data_q;
  logic            invalid_q;

  assign idle     = (state == ST_IDLE);
  assign bad_pair = quad_i & rt_i[0];
  assign accept   = start_i & idle & ~bad_pair;

  mreg_seq_ctrl #(.SW(SW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .rsp_i    (rd_rsp_i),
    .last_i   (last),
    .state_o  (state),
    .step_o   (step)
  );

  mreg_addr_gen #(
    .AW(AW), .XLEN(XLEN), .WORD_W(WORD_W), .RW(RW), .SW(SW)
  ) u_addr (
    .base_i (base_q),
    .rt_i   (rt_q),
    .step_i (step),
    .quad_i (quad_q),
    .le_i   (le_q),
    .addr_o (cur_addr),
    .reg_o  (cur_reg),
    .last_o (last)
  );

  mreg_data_fmt #(.XLEN(XLEN), .WORD_W(WORD_W)) u_fmt (
    .raw_i  (rd_data_i),
    .quad_i (quad_q),
    .le_i   (le_q),
    .fmt_o  (fmt_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      rt_q      <= '0;
      quad_q    <= 1'b0;
      le_q      <= 1'b0;
      invalid_q <= 1'b0;
    end else begin
      invalid_q <= start_i & idle & bad_pair;
      if (accept) begin
        base_q <= ea_i;
        rt_q   <= rt_i;
        quad_q <= quad_i;
        le_q   <= le_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_reg_q  <= '0;
      wr_data_q <= '0;
    end else if (state == ST_WAIT && rd_rsp_i) begin
      wr_reg_q  <= cur_reg;
      wr_data_q <= fmt_data;
    end
  end

  assign rd_req_o   = (state == ST_ISSUE);
  assign rd_addr_o  = cur_addr;
  assign rd_dword_o = quad_q;
  assign wr_en_o    = (state == ST_WRITE);
  assign wr_reg_o   = wr_reg_q;
  assign wr_data_o  = wr_data_q;
  assign busy_o     = ~idle;
  assign done_o     = (state == ST_DONE);
  assign invalid_o  = invalid_q;
endmodule

// File: rtl/mreg_load_seq_chk.sv
module mreg_load_seq_chk #(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32,
  parameter int RW     = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rd_req_o,
  input logic                 rd_rsp_i,
  input logic                 wr_en_o,
  input logic [RW-1:0]        wr_reg_o,
  input logic [XLEN-WORD_W-1:0] wr_hi,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 invalid_o,
  input logic                 quad_q
);
  logic          pending;
  logic [RW-1:0] prev_reg;
  logic          prev_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending  <= 1'b0;
      prev_reg <= '0;
      prev_vld <= 1'b0;
    end else begin
      if (rd_req_o)      pending <= 1'b1;
      else if (rd_rsp_i) pending <= 1'b0;
      if (done_o) prev_vld <= 1'b0;
      else if (wr_en_o && !quad_q) begin
        prev_vld <= 1'b1;
        prev_reg <= wr_reg_o;
      end
    end
  end

  a_r7_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !pending);
  a_r7_req_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  a_r8_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(wr_en_o));
  a_r8_done_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  a_r6_invalid_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (!busy_o && !rd_req_o && !wr_en_o));
  a_r9_busy_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !quad_q) |-> (wr_hi == '0));
  a_r2_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !quad_q && prev_vld) |-> (wr_reg_o == prev_reg + 1'b1));
endmodule

bind mreg_load_seq mreg_load_seq_chk #(.XLEN(XLEN), .WORD_W(WORD_W), .RW(RW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_req_o  (rd_req_o),
  .rd_rsp_i  (rd_rsp_i),
  .wr_en_o   (wr_en_o),
  .wr_reg_o  (wr_reg_o),
  .wr_hi     (wr_data_o[XLEN-1:WORD_W]),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .invalid_o (invalid_o),
  .quad_q    (quad_q)
);

// File: tb/sim_mreg_load_seq.sv
module sim_mreg_load_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, quad_i = 1'b0, le_i = 1'b0;
  logic [4:0]  rt_i = '0;
  logic [63:0] ea_i = '0;
  logic        rd_req_o, rd_dword_o, rd_rsp_i = 1'b0;
  logic [63:0] rd_addr_o, rd_data_i = '0;
  logic        wr_en_o, busy_o, done_o, invalid_o;
  logic [4:0]  wr_reg_o;
  logic [63:0] wr_data_o;

  always #2 clk = ~clk;

  mreg_load_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .quad_i(quad_i), .le_i(le_i),
    .rt_i(rt_i), .ea_i(ea_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_dword_o(rd_dword_o), .rd_rsp_i(rd_rsp_i), .rd_data_i(rd_data_i),
    .wr_en_o(wr_en_o), .wr_reg_o(wr_reg_o), .wr_data_o(wr_data_o),
    .busy_o(busy_o), .done_o(done_o), .invalid_o(invalid_o)
  );

  int n_chk = 0, n_fail = 0;
  // reference model state
  bit m_busy = 0, m_done_due = 0, m_inv_due = 0, m_out = 0;
  logic [63:0] q_addr[$], q_data[$];
  bit          q_sz[$];
  logic [4:0]  q_reg[$];
  bit          pend = 0, pend_sz = 0;
  int          pend_wait = 0, lat = 0;
  logic [63:0] pend_addr = '0;
  string       tag_req = "R3", tag_reg = "R2", tag_dat = "R3";

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp, string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(logic [63:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [63:0] mem_rd(logic [63:0] a, bit dw);
    logic [63:0] d = '0;
    if (dw) for (int i = 0; i < 8; i++) d[63-8*i -: 8] = mb(a + 64'(i));
    else begin
      d[63:32] = 32'hDEAD_BEEF;
      for (int i = 0; i < 4; i++) d[31-8*i -: 8] = mb(a + 64'(i));
    end
    return d;
  endfunction

  function automatic logic [63:0] rev8(logic [63:0] d);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = d[63-8*i -: 8];
    return r;
  endfunction

  task automatic tick(bit st, bit kd, logic [4:0] rt, logic [63:0] ea, bit le);
    bit was_busy;
    bit nd;
    @(negedge clk);
    was_busy = m_busy;
    nd = 0;
    check(busy_o == m_busy, "R9", 64'(busy_o), 64'(m_busy), "busy");
    check(done_o == m_done_due, "R8", 64'(done_o), 64'(m_done_due), "done");
    check(invalid_o == m_inv_due, "R6", 64'(invalid_o), 64'(m_inv_due), "invalid");
    if (rd_req_o) begin
      check(!m_out, "R7", 64'(m_out), 64'd0, "read while one outstanding");
      if (q_addr.size() == 0) check(0, tag_req, 64'd1, 64'd0, "unexpected read");
      else begin
        check(rd_addr_o == q_addr[0], tag_req, rd_addr_o, q_addr[0], "read address");
        check(rd_dword_o == q_sz[0], tag_req, 64'(rd_dword_o), 64'(q_sz[0]), "read size");
        void'(q_addr.pop_front());
        void'(q_sz.pop_front());
      end
    end
    if (wr_en_o) begin
      if (q_reg.size() == 0) check(0, tag_reg, 64'd1, 64'd0, "unexpected write");
      else begin
        check(wr_reg_o == q_reg[0], tag_reg, 64'(wr_reg_o), 64'(q_reg[0]), "write register");
        check(wr_data_o == q_data[0], tag_dat, wr_data_o, q_data[0], "write data");
        void'(q_reg.pop_front());
        void'(q_data.pop_front());
        if (q_reg.size() == 0) nd = 1;
      end
    end
    if (done_o) m_busy = 0;
    m_done_due = nd;
    m_inv_due = 0;
    // memory responder
    rd_rsp_i = 1'b0;
    if (pend) begin
      if (pend_wait == 0) begin
        rd_rsp_i  = 1'b1;
        rd_data_i = mem_rd(pend_addr, pend_sz);
        pend = 0;
        m_out = 0;
      end else pend_wait--;
    end
    if (rd_req_o) begin
      pend = 1; pend_wait = lat; pend_addr = rd_addr_o; pend_sz = rd_dword_o; m_out = 1;
    end
    // stimulus
    start_i = st; quad_i = kd; rt_i = rt; ea_i = ea; le_i = le;
    if (st && !was_busy) begin
      if (kd && rt[0]) m_inv_due = 1;
      else begin
        m_busy = 1;
        if (!kd) begin
          for (int k = 0; int'(rt) + k <= 31; k++) begin
            logic [63:0] a = ea + 64'(4*k);
            q_addr.push_back(a); q_sz.push_back(0);
            q_reg.push_back(rt + 5'(k));
            q_data.push_back({32'd0, mem_rd(a, 0)} & 64'h0000_0000_FFFF_FFFF);
          end
        end else begin
          for (int k = 0; k < 2; k++) begin
            logic [63:0] a = ea + 64'(8*k);
            q_addr.push_back(a); q_sz.push_back(1);
            q_reg.push_back(le ? rt + 5'(1 - k) : rt + 5'(k));
            q_data.push_back(le ? rev8(mem_rd(a, 1)) : mem_rd(a, 1));
          end
        end
      end
    end
  endtask

  task automatic idle_tick();
    tick(0, 0, 5'd0, 64'd0, 0);
  endtask

  task automatic finish_op(string tg);
    for (int i = 0; i < 1000 && (m_busy || m_done_due); i++) idle_tick();
    idle_tick();
    idle_tick();
    check(q_reg.size() == 0, tg, 64'(q_reg.size()), 64'd0, "writes left over");
  endtask

  task automatic run_op(bit kd, logic [4:0] rt, logic [63:0] ea, bit le, int l,
                        string tr, string tg, string td);
    lat = l; tag_req = tr; tag_reg = tg; tag_dat = td;
    tick(1, kd, rt, ea, le);
    finish_op(tg);
  endtask

  initial begin
    repeat (3) idle_tick();
    rst_ni = 1'b1;
    // R1 reset state
    @(negedge clk);
    check(!busy_o && !done_o && !invalid_o, "R1", {61'd0, busy_o, done_o, invalid_o}, 64'd0, "status after reset");
    check(!rd_req_o && !wr_en_o, "R1", {62'd0, rd_req_o, wr_en_o}, 64'd0, "commands after reset");
    // R2/R3 short walk, immediate response
    run_op(0, 5'd29, 64'h1000, 0, 0, "R3", "R2", "R3");
    // R2 single register at the top
    run_op(0, 5'd31, 64'h2004, 0, 1, "R3", "R2", "R3");
    // R2 full walk from register 0 with latency
    run_op(0, 5'd0, 64'h0000_0001_0000_0FF0, 0, 2, "R3", "R2", "R3");
    // R4 big-endian pair
    run_op(1, 5'd4, 64'h3000, 0, 0, "R4", "R4", "R4");
    // R5 little-endian pair
    run_op(1, 5'd10, 64'h4ABC, 1, 3, "R5", "R5", "R5");
    // R6 odd target refused
    run_op(1, 5'd7, 64'h5000, 0, 0, "R6", "R6", "R6");
    run_op(1, 5'd31, 64'h5100, 1, 0, "R6", "R6", "R6");
    // R9 start during busy ignored
    lat = 1; tag_req = "R9"; tag_reg = "R9"; tag_dat = "R9";
    tick(1, 0, 5'd28, 64'h6000, 0);
    idle_tick(); idle_tick();
    tick(1, 1, 5'd2, 64'h7000, 1);
    idle_tick();
    tick(1, 0, 5'd0, 64'h7100, 0);
    for (int i = 0; i < 1000 && !m_done_due; i++) idle_tick();
    // start in the done cycle is ignored too
    tick(1, 1, 5'd6, 64'h7200, 0);
    finish_op("R9");
    // R8 back-to-back operations after completion
    run_op(1, 5'd30, 64'h8000, 1, 1, "R5", "R8", "R5");
    run_op(0, 5'd30, 64'h8100, 0, 0, "R3", "R8", "R3");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule